// File: doc/BRIEF.md
# Source-selecting clock divider with input-specific pre-scaler

This block derives the clock of a small embedded controller from one of four free-running source clocks. A single 32-bit control word, written from a bus-clock domain, picks the source and sets two integer dividers. A pre-scaler of 1 to 32 sits only on the path of source 3. A shared post-divider of 1 to 4 follows whatever the selector passes on. For source 3 the output rate is the source rate divided by the pre-scaler ratio and then by the post-divider ratio. For the other sources only the post-divider applies.

Two kinds of write exist. A full write loads every field. A divider-only write loads the two ratio fields and leaves the source selection as it was. Source changes go through a break-before-make handshake, so the output never carries a truncated pulse. Ratio changes are taken on only at the end of a divided period. A ratio of one passes the clock in front of that divider straight through. Odd ratios keep the output high for the smaller half of the period.

Top module: `clkgen_muxdiv`

## Requirements
- R1: After reset the read-back word is 0, and the output runs at the source 0 rate (12 ns period, 6 ns high in the bench).
- R2: A full write stores the source select in bits 17:16, the pre-scaler ratio minus one in bits 12:8 and the post-divider ratio minus one in bits 5:4. Every other bit reads back as 0, whatever was written to it.
- R3: A divider-only write (wr_div_only = 1) updates bits 12:8 and 5:4 and keeps bits 17:16 unchanged.
- R4: For select codes 0, 1 and 2, the output period is the source period times the post-divider ratio, and the pre-scaler field has no effect.
- R5: For select code 3, the output period is the source period times the pre-scaler ratio times the post-divider ratio.
- R6: With both ratios at one, the output follows the chosen source, including its high time.
- R7: A divider with ratio N drives its output high for floor(N/2) cycles of its input clock. For N = 1 it passes its input through.
- R8: At most one source is enabled at any time. A source change produces no output pulse shorter than the shortest half period of the old or the new clock.
- R9: A ratio change in either divider takes effect only at the end of a period of that divider's output, never part-way through one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Clock of the control-word write and read port |
| rst | input | 1 | Synchronous active-high reset, bus_clk domain |
| src_clk | input | 4 | Source clocks; bit i is selected by select code i |
| wr_en | input | 1 | Write strobe for the control word |
| wr_div_only | input | 1 | With wr_en: update only the two ratio fields |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Registered read-back of the control word |
| clk_out | output | 1 | Divided output clock |

## Verification
The output period and high time are timed for every select code, with pre-scaler values that should be ignored on sources 0 to 2 and that must multiply the ratio on source 3. This separates a pre-scaler wrongly placed on every input from one that is missing on input 3. Even and odd ratios, and the all-ones bypass, tell the duty-cycle rule apart from the pass-through path. Source changes and ratio changes are done while a pulse-width monitor is running. Writes carry junk in the unused bits and a conflicting select code in divider-only writes, so that field masking and select preservation are checked through the read-back word.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 2;
  localparam int SEL_LSB  = 16;
  localparam int PRE_W    = 5;
  localparam int PRE_LSB  = 8;
  localparam int POST_W   = 2;
  localparam int POST_LSB = 4;
  localparam int NSRC     = 1 << SEL_W;
  localparam int PRE_SRC  = NSRC - 1;   // only this leg carries the pre-scaler

  localparam logic [REG_W-1:0] FIELD_MASK =
      (REG_W'((1 << SEL_W) - 1)  << SEL_LSB) |
      (REG_W'((1 << PRE_W) - 1)  << PRE_LSB) |
      (REG_W'((1 << POST_W) - 1) << POST_LSB);

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } cdiv_cfg_t;

  function automatic cdiv_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    cdiv_cfg_t c;
    c.sel  = w[SEL_LSB  +: SEL_W];
    c.pre  = w[PRE_LSB  +: PRE_W];
    c.post = w[POST_LSB +: POST_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input cdiv_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[SEL_LSB  +: SEL_W]  = c.sel;
    w[PRE_LSB  +: PRE_W]  = c.pre;
    w[POST_LSB +: POST_W] = c.post;
    return w;
  endfunction
endpackage

// File: rtl/cdiv_sync.sv
// Two-stage synchronizer for quasi-static values; clears to zero on rst.
module cdiv_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cdiv_intdiv.sv
// Integer clock divider. Ratio is (ratio_m1 + 1); a new ratio is loaded only
// when the current period ends. Ratio 1 bypasses the counter output.
module cdiv_intdiv #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio_m1,
  output logic          clk_o,
  output logic [CW-1:0] cur_m1,
  output logic          wrap
);
  logic [CW-1:0] cnt;
  logic          hi_q;
  logic [CW:0]   cnt_nx;
  logic [CW:0]   half_cur;

  assign wrap     = (cnt == cur_m1);
  assign cnt_nx   = {1'b0, cnt} + (CW+1)'(1);
  assign half_cur = ({1'b0, cur_m1} + (CW+1)'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cur_m1 <= '0;
      hi_q   <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      cur_m1 <= ratio_m1;
      hi_q   <= (ratio_m1 != '0);
    end else begin
      cnt    <= cnt_nx[CW-1:0];
      hi_q   <= (cnt_nx < half_cur);
    end
  end

  assign clk_o = (cur_m1 == '0) ? clk : hi_q;
endmodule

// File: rtl/cdiv_gfmux.sv
// Break-before-make clock selector. Each leg's enable lives in that leg's own
// clock domain, changes on its falling edge, and rises only after every other
// enable has been seen low through two stages.
module cdiv_gfmux #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic          rst,
  input  logic [SW-1:0] sel,
  input  logic [N-1:0]  clk_in,
  output logic [N-1:0]  en,
  output logic          clk_o
);
  for (genvar i = 0; i < N; i++) begin : g_leg
    logic [1:0] rst_s;
    logic [1:0] en_s;
    logic       want;

    assign want = (sel == SW'(i)) && ((en & ~(N'(1) << i)) == '0);

    always_ff @(negedge clk_in[i]) begin
      rst_s <= {rst_s[0], rst};
    end

    always_ff @(negedge clk_in[i]) begin
      if (rst_s[1]) begin
        en_s <= (i == 0) ? 2'b11 : 2'b00;
      end else begin
        en_s <= {en_s[0], want};
      end
    end

    assign en[i] = en_s[1];
  end

  assign clk_o = |(clk_in & en);
endmodule

// File: rtl/cdiv_regs.sv
// Control word: full write or ratio-only write; unused bits are not stored.
module cdiv_regs
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_div_only,
  input  logic [REG_W-1:0] wr_data,
  output cdiv_cfg_t        cfg,
  output logic [REG_W-1:0] rd_data
);
  cdiv_cfg_t wr_cfg;

  assign wr_cfg = cfg_from_word(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.pre  <= wr_cfg.pre;
      cfg.post <= wr_cfg.post;
      if (!wr_div_only) begin
        cfg.sel <= wr_cfg.sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= cfg_to_word(cfg);
    end
  end
endmodule

// File: rtl/clkgen_muxdiv.sv
module clkgen_muxdiv
  import cdiv_pkg::*;
(
  input  logic             bus_clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_clk,
  input  logic             wr_en,
  input  logic             wr_div_only,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out
);
  cdiv_cfg_t cfg;

  cdiv_regs u_regs (
    .clk         (bus_clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_div_only (wr_div_only),
    .wr_data     (wr_data),
    .cfg         (cfg),
    .rd_data     (rd_data)
  );

  // Pre-scaler, clocked by the one source that carries it
  logic             pre_rst;
  logic [PRE_W-1:0] pre_m1;
  logic [PRE_W-1:0] pre_cur_m1;
  logic             pre_wrap;
  logic             pre_clk;

  cdiv_sync #(.W(1)) u_pre_rst (
    .clk (src_clk[PRE_SRC]),
    .rst (1'b0),
    .d   (rst),
    .q   (pre_rst)
  );

  cdiv_sync #(.W(PRE_W)) u_pre_cfg (
    .clk (src_clk[PRE_SRC]),
    .rst (pre_rst),
    .d   (cfg.pre),
    .q   (pre_m1)
  );

  cdiv_intdiv #(.CW(PRE_W)) u_pre (
    .clk      (src_clk[PRE_SRC]),
    .rst      (pre_rst),
    .ratio_m1 (pre_m1),
    .clk_o    (pre_clk),
    .cur_m1   (pre_cur_m1),
    .wrap     (pre_wrap)
  );

  // Selector legs
  logic [NSRC-1:0] leg_clk;
  logic [NSRC-1:0] src_en;
  logic            mux_clk;

  for (genvar i = 0; i < NSRC; i++) begin : g_legs
    if (i == PRE_SRC) begin : g_scaled
      assign leg_clk[i] = pre_clk;
    end else begin : g_direct
      assign leg_clk[i] = src_clk[i];
    end
  end

  cdiv_gfmux #(.N(NSRC), .SW(SEL_W)) u_mux (
    .rst    (rst),
    .sel    (cfg.sel),
    .clk_in (leg_clk),
    .en     (src_en),
    .clk_o  (mux_clk)
  );

  // Post-divider, clocked by the selected leg
  logic              post_rst;
  logic [POST_W-1:0] post_m1;
  logic [POST_W-1:0] post_cur_m1;
  logic              post_wrap;
  logic              post_clk;

  cdiv_sync #(.W(1)) u_post_rst (
    .clk (mux_clk),
    .rst (1'b0),
    .d   (rst),
    .q   (post_rst)
  );

  cdiv_sync #(.W(POST_W)) u_post_cfg (
    .clk (mux_clk),
    .rst (post_rst),
    .d   (cfg.post),
    .q   (post_m1)
  );

  cdiv_intdiv #(.CW(POST_W)) u_post (
    .clk      (mux_clk),
    .rst      (post_rst),
    .ratio_m1 (post_m1),
    .clk_o    (post_clk),
    .cur_m1   (post_cur_m1),
    .wrap     (post_wrap)
  );

  assign clk_out = post_clk;
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
  import cdiv_pkg::*;
(
  input logic              bus_clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_div_only,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [REG_W-1:0]  rd_data,
  input logic [NSRC-1:0]   src_en,
  input logic              mux_clk,
  input logic              post_rst,
  input logic [POST_W-1:0] post_cur_m1,
  input logic              post_wrap,
  input logic              pre_clk_in,
  input logic              pre_rst,
  input logic [PRE_W-1:0]  pre_cur_m1,
  input logic              pre_wrap
);
  AST_SEL_HELD: assert property (@(posedge bus_clk) disable iff (rst)
    (wr_en && wr_div_only) |=> $stable(cfg_sel)); // R3

  AST_UNLISTED_ZERO: assert property (@(posedge bus_clk) disable iff (rst)
    ((rd_data & ~FIELD_MASK) == '0)); // R2

  AST_ONE_SOURCE: assert property (@(posedge bus_clk) disable iff (rst)
    $onehot0(src_en)); // R8

  AST_POST_AT_BOUNDARY: assert property (@(posedge mux_clk) disable iff (post_rst)
    (post_cur_m1 != $past(post_cur_m1)) |-> $past(post_wrap)); // R9

  AST_PRE_AT_BOUNDARY: assert property (@(posedge pre_clk_in) disable iff (pre_rst)
    (pre_cur_m1 != $past(pre_cur_m1)) |-> $past(pre_wrap)); // R9
endmodule

bind clkgen_muxdiv cdiv_checker u_chk (
  .bus_clk     (bus_clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_div_only (wr_div_only),
  .cfg_sel     (cfg.sel),
  .rd_data     (rd_data),
  .src_en      (src_en),
  .mux_clk     (mux_clk),
  .post_rst    (post_rst),
  .post_cur_m1 (post_cur_m1),
  .post_wrap   (post_wrap),
  .pre_clk_in  (src_clk[PRE_SRC]),
  .pre_rst     (pre_rst),
  .pre_cur_m1  (pre_cur_m1),
  .pre_wrap    (pre_wrap)
);

// File: tb/sim_clkgen_muxdiv.sv
`timescale 1ns/1ps
module sim_clkgen_muxdiv;
  logic        bus_clk = 1'b0;
  logic        rst = 1'b1;
  logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  logic [3:0]  src_clk;
  logic        wr_en = 1'b0;
  logic        wr_div_only = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] JUNK = 32'hA5A5_A5A5 & ~32'h0003_1F30;

  always #5 bus_clk = ~bus_clk;   // 100 MHz
  always #6  s0 = ~s0;            // 12 ns
  always #10 s1 = ~s1;            // 20 ns
  always #7  s2 = ~s2;            // 14 ns
  always #3  s3 = ~s3;            // 6 ns
  assign src_clk = {s3, s2, s1, s0};

  clkgen_muxdiv u0 (
    .bus_clk     (bus_clk),
    .rst         (rst),
    .src_clk     (src_clk),
    .wr_en       (wr_en),
    .wr_div_only (wr_div_only),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .clk_out     (clk_out)
  );

  // pulse-width monitor
  bit  mon_on = 1'b0;
  bit  mon_armed = 1'b0;
  real last_edge = 0.0;
  real min_w = 1.0e9;
  always @(clk_out) begin
    if (mon_on) begin
      if (mon_armed && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
      mon_armed = 1'b1;
      last_edge = $realtime;
    end
  end

  function automatic real src_t(input int s);
    case (s)
      0: return 12.0;
      1: return 20.0;
      2: return 14.0;
      default: return 6.0;
    endcase
  endfunction

  function automatic real exp_per(input int s, input int pre, input int post);
    real p;
    p = src_t(s) * (post + 1);
    if (s == 3) p = p * (pre + 1);
    return p;
  endfunction

  function automatic real exp_hi(input int s, input int pre, input int post);
    int  pr;
    real tin;
    real hin;
    pr  = (s == 3) ? pre + 1 : 1;
    tin = src_t(s) * pr;
    hin = (pr == 1) ? src_t(s) / 2.0 : src_t(s) * (pr / 2);
    if (post == 0) return hin;
    return tin * ((post + 1) / 2);
  endfunction

  task automatic chk_word(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input real act, input real exp);
    n_chk++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic chk_min(input string req, input real act, input real lim);
    n_chk++;
    if (act < lim - 0.01) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected>=%0.3f", req, act, lim);
    end
  endtask

  task automatic bus_write(input logic [31:0] d, input logic div_only);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_div_only = div_only; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0; wr_div_only = 1'b0; wr_data = '0;
    repeat (3) @(negedge bus_clk);
  endtask

  function automatic logic [31:0] word(input int s, input int pre, input int post);
    return (32'(s) << 16) | (32'(pre) << 8) | (32'(post) << 4);
  endfunction

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    #4000;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic run_cfg(input string req, input int s, input int pre, input int post);
    real per, hi;
    bus_write(JUNK | word(s, pre, post), 1'b0);
    measure(per, hi);
    chk_time({req, " period"}, per, exp_per(s, pre, post));
    chk_time({req, " high"}, hi, exp_hi(s, pre, post));
  endtask

  task automatic t_reset();
    real per, hi;
    @(negedge bus_clk);
    chk_word("R1 reset readback", rd_data, 32'h0);
    measure(per, hi);
    chk_time("R1 reset period", per, 12.0);
    chk_time("R1 reset high", hi, 6.0);
  endtask

  task automatic t_fields();
    bus_write(32'hFFFF_FFFF, 1'b0);
    chk_word("R2 all-ones write", rd_data, 32'h0003_1F30);
    bus_write(JUNK | word(2, 21, 1), 1'b0);
    chk_word("R2 field write", rd_data, word(2, 21, 1));
  endtask

  task automatic t_div_update();
    real per, hi;
    bus_write(word(1, 0, 0), 1'b0);
    bus_write(JUNK | word(3, 9, 2), 1'b1);   // select bits must not change
    chk_word("R3 divider-only write", rd_data, word(1, 9, 2));
    measure(per, hi);
    chk_time("R3 source kept after divider-only write", per, 60.0);
  endtask

  task automatic t_plain_sources();
    run_cfg("R4 src1 pre ignored /3", 1, 7, 2);
    run_cfg("R4 src2 /2", 2, 13, 1);
    run_cfg("R4 src0 /4 pre ignored", 0, 31, 3);
  endtask

  task automatic t_scaled_source();
    run_cfg("R5 src3 5x2", 3, 4, 1);
    run_cfg("R5 src3 3x3", 3, 2, 2);
    run_cfg("R5 src3 32x4", 3, 31, 3);
  endtask

  task automatic t_bypass_duty();
    run_cfg("R6 src3 bypass", 3, 0, 0);
    run_cfg("R6 src1 bypass", 1, 0, 0);
    run_cfg("R7 odd pre 5 alone", 3, 4, 0);
    run_cfg("R7 odd post 3", 2, 0, 2);
    run_cfg("R7 even post 4", 1, 0, 3);
  endtask

  task automatic t_switch();
    bus_write(word(0, 0, 0), 1'b0);
    #2000;
    min_w = 1.0e9; mon_armed = 1'b0; mon_on = 1'b1;
    bus_write(word(1, 0, 0), 1'b0);
    #1500;
    bus_write(word(3, 0, 0), 1'b0);
    #1500;
    bus_write(word(2, 0, 0), 1'b0);
    #1500;
    mon_on = 1'b0;
    chk_min("R8 no runt pulse on source change", min_w, 3.0);
    bus_write(word(0, 0, 0), 1'b0);
    #2000;
    min_w = 1.0e9; mon_armed = 1'b0; mon_on = 1'b1;
    bus_write(word(1, 0, 0), 1'b0);
    #1500;
    mon_on = 1'b0;
    chk_min("R8 src0 to src1 pulses", min_w, 6.0);
  endtask

  task automatic t_ratio_change();
    bus_write(word(1, 0, 3), 1'b0);
    #2000;
    min_w = 1.0e9; mon_armed = 1'b0; mon_on = 1'b1;
    for (int k = 0; k < 6; k++) begin
      bus_write(word(1, 0, (k % 2 == 0) ? 2 : 3), 1'b1);
      #(37 + 11 * k);
    end
    #1500;
    mon_on = 1'b0;
    chk_min("R9 post ratio change at boundary", min_w, 20.0);
    bus_write(word(3, 7, 0), 1'b0);
    #2000;
    min_w = 1.0e9; mon_armed = 1'b0; mon_on = 1'b1;
    bus_write(word(3, 2, 0), 1'b1);
    #1500;
    mon_on = 1'b0;
    chk_min("R9 pre ratio change at boundary", min_w, 6.0);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20) @(negedge bus_clk);
    rst = 1'b0;
    repeat (5) @(negedge bus_clk);
    t_reset();
    t_fields();
    t_div_update();
    t_plain_sources();
    t_scaled_source();
    t_bypass_duty();
    t_switch();
    t_ratio_change();
    if (!done) begin
      summary();
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule